// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns virtual addresses into physical addresses for one requester, one access at a time. Pages and frames are 4 KB, so the low twelve address bits pass through unchanged and only the page number is translated. A small fully associative translation cache holds recent page-to-frame pairs. It is searched first. Only on a miss does the block ask a page-table port for the entry.

Each entry carries a present flag, referenced and dirty flags, read, write and execute permissions and a frame number. An access to a non-present page ends with a page fault. An access that the permissions forbid ends with a protection fault. A permitted access that would change the referenced or dirty flag sends the new flags back to the page table through a write-back strobe.

Accesses enter on a valid/ready request channel and leave on a valid/ready response channel. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Once `rsp_valid` rises, the address and fault code stay frozen until a clock edge that samples `rsp_ready` high. Only then does `req_ready` return. Flush, reset and the page-table pins are plain control signals.

Top module: `paged_xlat_unit`

## Requirements
- R1: A successful translation returns `rsp_paddr` = {frame number, vaddr[11:0]}, and `rsp_fault` = 2'b00.
- R2: When the page is cached, the access makes no page-table request, and `rsp_valid` rises two clock edges after the accepting edge.
- R3: On a miss the block makes exactly one page-table lookup for the page and caches the returned present entry. A later access to that page makes no lookup.
- R4: If the returned entry has present=0, the response is a page fault: `rsp_fault` = 2'b01 and `rsp_paddr` = 0. Nothing is cached, so a repeat access looks the page up again, and no write-back occurs. The page-fault check is made before the permission check.
- R5: Access kinds are encoded as 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. If the entry lacks the permission for the kind, or the kind is reserved, the response is a protection fault: `rsp_fault` = 2'b10 and `rsp_paddr` = 0. There is no write-back. The entry stays cached.
- R6: A permitted access to an entry whose referenced flag is 0 gives exactly one write-back strobe, with that page number and referenced=1. A later read of the same page gives none.
- R7: A permitted write to an entry whose dirty flag is 0 gives one write-back, with dirty=1 and referenced=1. A second write to the same page gives none.
- R8: Fills go to successive cache slots in round-robin order. After the cache holds ENTRIES pages, the next fill evicts the page filled earliest.
- R9: A one-cycle `flush` pulse invalidates every cached entry, so the next access to any page performs a lookup.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` stays low. Only one access is in flight.
- R11: `pt_req_valid` stays high with a stable `pt_req_vpn` until a clock edge that samples `pt_rsp_valid` high.
- R12: After reset, `req_ready`=1, `rsp_valid`=0, `pt_req_valid`=0, `pt_wb_valid`=0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 execute) |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes response |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| pt_req_valid | output | 1 | Page-table lookup pending |
| pt_req_vpn | output | VA_W-12 | Page number being looked up |
| pt_rsp_valid | input | 1 | Page-table entry returned |
| pt_rsp_present | input | 1 | Entry present flag |
| pt_rsp_dirty | input | 1 | Entry dirty flag |
| pt_rsp_ref | input | 1 | Entry referenced flag |
| pt_rsp_rd | input | 1 | Read permitted |
| pt_rsp_wr | input | 1 | Write permitted |
| pt_rsp_ex | input | 1 | Execute permitted |
| pt_rsp_pfn | input | PA_W-12 | Frame number |
| pt_wb_valid | output | 1 | Write-back strobe for flag update |
| pt_wb_vpn | output | VA_W-12 | Page number being updated |
| pt_wb_ref | output | 1 | New referenced flag |
| pt_wb_dirty | output | 1 | New dirty flag |

## Verification
Each fault in the cache contents shows up at the ports within one access. A stale or lost tag appears as a page-table lookup that should not happen, or one that is missing. A wrong frame appears as a wrong `rsp_paddr` two edges after acceptance. A flag that did not update appears on the next access as a duplicate or missing write-back strobe. A round-robin pointer that steps wrongly shows only after a full cache's worth of fills, so the bench fills every slot and then probes which page was evicted. The page-table model in the bench keeps the flags written back to it, so flags lost across a flush appear as an extra strobe after the refill.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {ACC_RD = 2'b00, ACC_WR = 2'b01, ACC_EX = 2'b10, ACC_RSV = 2'b11} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_PAGE = 2'b01, FLT_PROT = 2'b10} flt_e;
  typedef struct packed {
    logic present;
    logic dirty;
    logic refd;
    logic rd;
    logic wr;
    logic ex;
  } pte_flags_t;
endpackage

// File: rtl/perm_gate.sv
module perm_gate
  import xlat_pkg::*;
(
  input  logic [1:0] kind,
  input  pte_flags_t flags,
  output logic       allowed,
  output logic       need_wb,
  output logic       new_ref,
  output logic       new_dirty
);
  logic is_wr;
  assign is_wr = (kind == ACC_WR);

  always_comb begin
    case (kind)
      ACC_RD:  allowed = flags.present & flags.rd;
      ACC_WR:  allowed = flags.present & flags.wr;
      ACC_EX:  allowed = flags.present & flags.ex;
      default: allowed = 1'b0;
    endcase
  end

  assign new_ref   = 1'b1;
  assign new_dirty = flags.dirty | is_wr;
  assign need_wb   = allowed & (~flags.refd | (is_wr & ~flags.dirty));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  output pte_flags_t       hit_flags,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  pte_flags_t       fill_flags,
  input  logic             upd_en,
  input  logic             upd_ref,
  input  logic             upd_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] used_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  pte_flags_t         flg_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   hit_idx;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = used_q[g] && (tag_q[g] == look_vpn);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign hit_pfn   = pfn_q[hit_idx];
  assign hit_flags = flg_q[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      rr_q   <= '0;
    end else if (flush) begin
      used_q <= '0;
    end else if (fill_en) begin
      used_q[rr_q] <= 1'b1;
      rr_q         <= rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && fill_en) begin
      tag_q[rr_q] <= fill_vpn;
      pfn_q[rr_q] <= fill_pfn;
      flg_q[rr_q] <= fill_flags;
    end else if (upd_en && hit) begin
      flg_q[hit_idx].refd  <= upd_ref;
      flg_q[hit_idx].dirty <= upd_dirty;
    end
  end

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hit_vec == '0));
endmodule

// File: rtl/paged_xlat_unit.sv
module paged_xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_kind,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_fault,
  output logic                  pt_req_valid,
  output logic [VA_W-OFF_W-1:0] pt_req_vpn,
  input  logic                  pt_rsp_valid,
  input  logic                  pt_rsp_present,
  input  logic                  pt_rsp_dirty,
  input  logic                  pt_rsp_ref,
  input  logic                  pt_rsp_rd,
  input  logic                  pt_rsp_wr,
  input  logic                  pt_rsp_ex,
  input  logic [PA_W-OFF_W-1:0] pt_rsp_pfn,
  output logic                  pt_wb_valid,
  output logic [VA_W-OFF_W-1:0] pt_wb_vpn,
  output logic                  pt_wb_ref,
  output logic                  pt_wb_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WALK, S_RESP} st_e;

  st_e              st_q;
  logic [VPN_W-1:0] cur_vpn;
  logic [OFF_W-1:0] cur_off;
  logic [1:0]       cur_kind;
  logic [PA_W-1:0]  paddr_q;
  logic [1:0]       fault_q;

  logic             hit, allowed, need_wb, new_ref, new_dirty;
  logic [PFN_W-1:0] hit_pfn;
  pte_flags_t       hit_flags, pt_flags;
  logic             fill_en, upd_en;

  assign pt_flags = {pt_rsp_present, pt_rsp_dirty, pt_rsp_ref, pt_rsp_rd, pt_rsp_wr, pt_rsp_ex};
  assign fill_en  = (st_q == S_WALK) && pt_rsp_valid && pt_rsp_present;
  assign upd_en   = (st_q == S_CHECK) && hit && need_wb;

  xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .look_vpn(cur_vpn),
    .hit(hit), .hit_pfn(hit_pfn), .hit_flags(hit_flags),
    .fill_en(fill_en), .fill_vpn(cur_vpn), .fill_pfn(pt_rsp_pfn), .fill_flags(pt_flags),
    .upd_en(upd_en), .upd_ref(new_ref), .upd_dirty(new_dirty)
  );

  perm_gate u_perm (
    .kind(cur_kind), .flags(hit_flags), .allowed(allowed),
    .need_wb(need_wb), .new_ref(new_ref), .new_dirty(new_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cur_vpn  <= '0;
      cur_off  <= '0;
      cur_kind <= '0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          cur_vpn  <= req_vaddr[VA_W-1:OFF_W];
          cur_off  <= req_vaddr[OFF_W-1:0];
          cur_kind <= req_kind;
          st_q     <= S_CHECK;
        end
        S_CHECK: if (hit) begin
          st_q <= S_RESP;
          if (allowed) begin
            paddr_q <= {hit_pfn, cur_off};
            fault_q <= FLT_NONE;
          end else begin
            paddr_q <= '0;
            fault_q <= FLT_PROT;
          end
        end else begin
          st_q <= S_WALK;
        end
        S_WALK: if (pt_rsp_valid) begin
          if (pt_rsp_present) begin
            st_q <= S_CHECK;
          end else begin
            st_q    <= S_RESP;
            paddr_q <= '0;
            fault_q <= FLT_PAGE;
          end
        end
        default: if (rsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st_q == S_IDLE);
  assign rsp_valid    = (st_q == S_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign pt_req_valid = (st_q == S_WALK);
  assign pt_req_vpn   = cur_vpn;
  assign pt_wb_valid  = upd_en;
  assign pt_wb_vpn    = cur_vpn;
  assign pt_wb_ref    = new_ref;
  assign pt_wb_dirty  = new_dirty;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  pt_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_rsp_valid) |=> (pt_req_valid && $stable(pt_req_vpn)));

  // R6
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wb_valid |=> (rsp_valid && rsp_fault == FLT_NONE));

  // R4
  page_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_PAGE) |-> (rsp_paddr == '0));
endmodule

// File: tb/sim_paged_xlat_unit.sv
`timescale 1ns/1ps
module sim_paged_xlat_unit;
  localparam int NV = 16;
  // vector: kind[38:37] vaddr[36:5] exp_fault[4:3] exp_lookups[2:1] exp_wb[0]
  localparam logic [38:0] VEC [NV] = '{
    {2'b00, 32'h0000_1123, 2'b00, 2'd1, 1'b1},  // R3 R6 miss, fill, ref write-back
    {2'b00, 32'h0000_1FFF, 2'b00, 2'd0, 1'b0},  // R2 hit, no lookup
    {2'b01, 32'h0000_1004, 2'b10, 2'd0, 1'b0},  // R5 write not allowed
    {2'b10, 32'h0000_1008, 2'b10, 2'd0, 1'b0},  // R5 exec not allowed
    {2'b01, 32'h0002_1010, 2'b00, 2'd1, 1'b1},  // R7 write miss sets dirty
    {2'b01, 32'h0002_1020, 2'b00, 2'd0, 1'b0},  // R7 second write silent
    {2'b00, 32'h0002_2040, 2'b00, 2'd1, 1'b1},  // R6 read sets ref only
    {2'b01, 32'h0002_2080, 2'b00, 2'd0, 1'b1},  // R7 write hit, dirty clear
    {2'b00, 32'h0000_F000, 2'b01, 2'd1, 1'b0},  // R4 page fault
    {2'b00, 32'h0000_F444, 2'b01, 2'd1, 1'b0},  // R4 not cached, looked up again
    {2'b10, 32'h0004_1ABC, 2'b00, 2'd1, 1'b1},  // R1 exec permitted
    {2'b00, 32'h0005_1000, 2'b10, 2'd1, 1'b0},  // R5 read denied after fill
    {2'b00, 32'h0005_1001, 2'b10, 2'd0, 1'b0},  // R5 denied entry stays cached
    {2'b11, 32'h0000_1000, 2'b10, 2'd0, 1'b0},  // R5 reserved kind
    {2'b00, 32'h0001_F000, 2'b01, 2'd1, 1'b0},  // R4 page fault before permission
    {2'b00, 32'hFFFE_1765, 2'b00, 2'd1, 1'b1}   // R1 high page number
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        pt_req_valid;
  logic [19:0] pt_req_vpn;
  logic        pt_rsp_valid = 1'b0;
  logic        pt_rsp_present = 1'b0, pt_rsp_dirty = 1'b0, pt_rsp_ref = 1'b0;
  logic        pt_rsp_rd = 1'b0, pt_rsp_wr = 1'b0, pt_rsp_ex = 1'b0;
  logic [19:0] pt_rsp_pfn = '0;
  logic        pt_wb_valid;
  logic [19:0] pt_wb_vpn;
  logic        pt_wb_ref, pt_wb_dirty;

  int          checks = 0;
  int          fails = 0;
  int          lookups = 0;
  int          wbs = 0;
  int          pt_delay = 0;
  int          pt_wait = 0;
  bit          pt_moved = 1'b0;
  logic [19:0] pt_seen;
  logic [19:0] last_wb_vpn;
  logic        last_wb_ref, last_wb_dirty;
  logic [1:0]  shadow [int unsigned];

  always #2 clk = ~clk;

  paged_xlat_unit u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn), .pt_rsp_valid(pt_rsp_valid),
    .pt_rsp_present(pt_rsp_present), .pt_rsp_dirty(pt_rsp_dirty), .pt_rsp_ref(pt_rsp_ref),
    .pt_rsp_rd(pt_rsp_rd), .pt_rsp_wr(pt_rsp_wr), .pt_rsp_ex(pt_rsp_ex), .pt_rsp_pfn(pt_rsp_pfn),
    .pt_wb_valid(pt_wb_valid), .pt_wb_vpn(pt_wb_vpn), .pt_wb_ref(pt_wb_ref), .pt_wb_dirty(pt_wb_dirty)
  );

  function automatic logic [19:0] pfn_of(logic [19:0] vpn);
    return vpn ^ 20'h5A5A5;
  endfunction

  function automatic logic [1:0] shadow_of(logic [19:0] vpn);
    if (shadow.exists(int'(vpn))) return shadow[int'(vpn)];
    return 2'b00;
  endfunction

  // page-table model: present unless vpn[3:0]==F; rd=~vpn[4], wr=vpn[5], ex=vpn[6]
  always @(negedge clk) begin
    if (pt_rsp_valid) begin
      pt_rsp_valid = 1'b0;
    end else if (pt_req_valid) begin
      if (pt_wait == 0) pt_seen = pt_req_vpn;
      else if (pt_req_vpn != pt_seen) pt_moved = 1'b1;
      if (pt_wait >= pt_delay) begin
        pt_rsp_present = (pt_req_vpn[3:0] != 4'hF);
        pt_rsp_rd      = ~pt_req_vpn[4];
        pt_rsp_wr      = pt_req_vpn[5];
        pt_rsp_ex      = pt_req_vpn[6];
        {pt_rsp_dirty, pt_rsp_ref} = shadow_of(pt_req_vpn);
        pt_rsp_pfn     = pfn_of(pt_req_vpn);
        pt_rsp_valid   = 1'b1;
        lookups++;
        pt_wait = 0;
      end else begin
        pt_wait++;
      end
    end
  end

  always @(negedge clk) begin
    if (pt_wb_valid) begin
      wbs++;
      last_wb_vpn   = pt_wb_vpn;
      last_wb_ref   = pt_wb_ref;
      last_wb_dirty = pt_wb_dirty;
      shadow[int'(pt_wb_vpn)] = {pt_wb_dirty, pt_wb_ref};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] va, input int hold,
                        output logic [31:0] pa, output logic [1:0] f,
                        output int nlk, output int nwb, output int lat);
    int lk0 = lookups;
    int wb0 = wbs;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_kind  = k;
    rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr;
    f  = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa && rsp_fault == f && !req_ready,
          "R10 stalled response held", {rsp_valid, req_ready, rsp_paddr}, {2'b10, pa});
    end
    rsp_ready = 1'b1;
    nlk = lookups - lk0;
    nwb = wbs - wb0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic [1:0]  f;
    int          nlk, nwb, lat;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready && !rsp_valid && !pt_req_valid && !pt_wb_valid, "R12 reset outputs",
        {req_ready, rsp_valid, pt_req_valid, pt_wb_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R12 idle after reset", {req_ready, rsp_valid}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      logic [1:0]  k, ef;
      logic [31:0] va, ep;
      logic [1:0]  pre;
      v  = VEC[i];
      k  = v[38:37];
      va = v[36:5];
      ef = v[4:3];
      pre = shadow_of(va[31:12]);
      ep = (ef == 2'b00) ? {pfn_of(va[31:12]), va[11:0]} : 32'h0;
      access(k, va, 0, pa, f, nlk, nwb, lat);
      chk(f == ef, $sformatf("R1/R4/R5 fault vec %0d", i), f, ef);
      chk(pa == ep, $sformatf("R1 paddr vec %0d", i), pa, ep);
      chk(nlk == int'(v[2:1]), $sformatf("R2/R3 lookups vec %0d", i), nlk, v[2:1]);
      chk(nwb == int'(v[0]), $sformatf("R6/R7 write-backs vec %0d", i), nwb, v[0]);
      if (nwb == 1)
        chk(last_wb_vpn == va[31:12] && last_wb_ref && last_wb_dirty == (pre[1] | (k == 2'b01)),
            $sformatf("R6/R7 write-back fields vec %0d", i),
            {last_wb_vpn, last_wb_ref, last_wb_dirty}, {va[31:12], 1'b1, pre[1] | (k == 2'b01)});
    end

    // R2 hit latency: response two edges after acceptance
    access(2'b00, 32'h0000_1234, 0, pa, f, nlk, nwb, lat);
    chk(lat == 2 && nlk == 0, "R2 hit latency", lat, 2);

    // R10 back-pressure on the response
    access(2'b00, 32'h0002_2999, 4, pa, f, nlk, nwb, lat);
    chk(pa == {pfn_of(20'h00022), 12'h999}, "R10 held paddr", pa, {pfn_of(20'h00022), 12'h999});

    // R11 slow page table
    pt_delay = 3;
    access(2'b00, 32'h0006_1000, 0, pa, f, nlk, nwb, lat);
    chk(!pt_moved && nlk == 1, "R11 lookup held stable", {pt_moved, nlk[3:0]}, 5'h01);
    chk(pa == {pfn_of(20'h00061), 12'h000}, "R11 slow lookup paddr", pa, {pfn_of(20'h00061), 12'h000});
    pt_delay = 0;

    // R9 flush: refill with stored flags, no extra write-back
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    access(2'b00, 32'h0000_1000, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 1, "R9 lookup after flush", nlk, 1);
    chk(nwb == 0, "R9 no write-back after refill", nwb, 0);
    access(2'b01, 32'h0002_1000, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 1 && nwb == 0, "R9 dirty page refilled silently", {nlk[3:0], nwb[3:0]}, 8'h10);

    // R8 round-robin eviction: 65 distinct pages, vpn = (i+1)<<7
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i <= 64; i++) begin
      logic [19:0] vp;
      vp = 20'((i + 1) << 7);
      access(2'b00, {vp, 12'h010}, 0, pa, f, nlk, nwb, lat);
      if (i == 64) chk(nlk == 1, "R8 extra page misses", nlk, 1);
    end
    access(2'b00, {20'h00100, 12'h0}, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 0, "R8 second page kept", nlk, 0);
    access(2'b00, {20'h00080, 12'h0}, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 1, "R8 oldest page evicted", nlk, 1);
    access(2'b00, {20'h00180, 12'h0}, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 0, "R8 third page kept", nlk, 0);
    access(2'b00, {20'h00100, 12'h0}, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 1, "R8 next oldest evicted by refill", nlk, 1);

    // R12 reset mid-run empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !pt_req_valid, "R12 reset again", {req_ready, rsp_valid, pt_req_valid}, 3'b100);
    rst_n = 1'b1;
    access(2'b00, 32'h0000_1000, 0, pa, f, nlk, nwb, lat);
    chk(nlk == 1, "R12 cache empty after reset", nlk, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule